// File: doc/BRIEF.md
# Transmit Pacing Rate Limiter

This block makes an output channel that accepts bytes instantly look, to the host, as if it ran at the programmed baud rate. It does not time each bit. It counts the bytes the host writes. When a byte completes a group, it holds back the transmit-ready event for a fixed pause of `PAUSE_TICKS` millisecond ticks, and then releases the event. Any other write produces the transmit-ready event at once. The group size is the number of 8-bit characters that fit into the pause at the current rate.

The host commits a new baud rate with a load strobe. The block recomputes the group size from that rate in integer arithmetic. Transmit-ready events and pacing take effect only while the transmit-interrupt enable is set. Writes are counted in every case.

Top module: `tx_pace_limiter`

## Requirements
- R1: After a synchronous active-low reset, `pace_busy` and `tx_ready_pulse` are low and the group size is the one for 115200 baud, which is 140 bytes. The within-group count is zero.
- R2: A commit with a non-zero `baud_in` sets the group size to floor(floor(baud/8)/1000)*10. The new size applies to writes from the cycle after the commit. For example, 9600 gives 10, 8000 gives 10, 38400 gives 40, 19200 gives 20 and 7999 gives 0.
- R3: When the group size is zero, every enabled write raises `tx_ready_pulse` in the next cycle and `pace_busy` never rises.
- R4: An enabled write that does not complete a group raises `tx_ready_pulse` for exactly one cycle, in the cycle after the write.
- R5: An enabled write that completes a group while no pause is running gives no pulse, and `pace_busy` is high from the next cycle. The group's own writes count toward completing it, so the first pause starts on write number group-size.
- R6: A pause ends on the `PAUSE_TICKS`-th `ms_tick` (10 by default) seen after the cycle in which it started. In the next cycle `pace_busy` is low and `tx_ready_pulse` is high for one cycle, whatever the state of `tx_int_en`. Ticks seen while no pause runs have no effect.
- R7: With `tx_int_en` low, a write advances the within-group count but produces no pulse and starts no pause.
- R8: A write during a running pause is counted and does not restart or extend the pause. If it does not complete a group it pulses at once. If it does complete a group, it gives no pulse and starts no new pause.
- R9: A commit with `baud_in` equal to zero is ignored and leaves both the group size and the count unchanged. A valid commit restarts the within-group count at zero and takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_wr | input | 1 | One-cycle strobe: the host wrote one byte |
| baud_load | input | 1 | One-cycle strobe: commit `baud_in` as the new rate |
| baud_in | input | 32 | Baud rate to commit; zero is invalid |
| tx_int_en | input | 1 | Transmit-interrupt enable |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| tx_ready_pulse | output | 1 | One-cycle transmit-ready event |
| pace_busy | output | 1 | High while a pause is running |

## Verification
Every result is registered once. A write, a tick or a commit presented before a rising edge is visible in the cycle after that edge. The bench drives each strobe at a falling edge and drops it at the next falling edge. It then samples `tx_ready_pulse` and `pace_busy` at once, half a cycle after the edge that acted on the strobe.

A commit is checked through the writes that follow it: the bench counts the writes until `pace_busy` rises. A pause is checked tick by tick: `pace_busy` must still be high after tick `PAUSE_TICKS`-1 and must be low, with a pulse, after tick `PAUSE_TICKS`.

// File: rtl/pace_pkg.sv
// Package: shared widths and defaults for the transmit pacing limiter.
// Assumes every character is counted as 8 bits regardless of framing.
package pace_pkg;
    localparam int BAUD_W        = 32;
    localparam int CNT_W         = 32;
    localparam int BITS_PER_CHAR = 8;
    localparam int MS_PER_PAUSE  = 10;
    localparam int RESET_BAUD    = 115200;

    typedef logic [BAUD_W-1:0] baud_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/pace_group_calc.sv
// Group-size register: holds the number of bytes per pacing group,
// computed as floor(floor(baud/BITS)/1000)*PAUSE_MS on each valid commit.
// Assumes a zero baud commit is invalid and must be ignored.
module pace_group_calc
    import pace_pkg::*;
#(
    parameter int BITS       = BITS_PER_CHAR,
    parameter int PAUSE_MS   = MS_PER_PAUSE,
    parameter int INIT_BAUD  = RESET_BAUD
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  baud_load,
    input  baud_t baud_in,
    output logic  commit_ok,
    output cnt_t  group_q
);
    localparam cnt_t INIT_GROUP = cnt_t'(((INIT_BAUD / BITS) / 1000) * PAUSE_MS);

    cnt_t group_next;

    // Qualify the commit and compute the candidate group size.
    always_comb begin
        commit_ok  = baud_load && (baud_in != '0);
        group_next = cnt_t'(((baud_in / baud_t'(BITS)) / baud_t'(1000)) * baud_t'(PAUSE_MS));
    end

    // Hold the group size; load it only on a valid commit.
    always_ff @(posedge clk) begin
        if (!rst_n)         group_q <= INIT_GROUP;
        else if (commit_ok) group_q <= group_next;
    end

    // R9
    zero_commit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_load && baud_in == '0) |=> $stable(group_q));
endmodule

// File: rtl/pace_byte_counter.sv
// Within-group byte counter: counts every written byte and wraps to zero
// when the group size is reached, giving a modulo test without a divider.
// Assumes group_q == 0 means pacing is off (count held at zero).
module pace_byte_counter
    import pace_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  cnt_t group_q,
    output logic boundary,
    output cnt_t in_grp_q
);
    cnt_t nxt_cnt;

    // Detect whether this write completes a group.
    always_comb begin
        nxt_cnt  = in_grp_q + cnt_t'(1);
        boundary = (group_q != '0) && (nxt_cnt == group_q);
    end

    // Advance, wrap or clear the within-group count.
    always_ff @(posedge clk) begin
        if (!rst_n)                             in_grp_q <= '0;
        else if (clr)                           in_grp_q <= '0;
        else if (inc && (boundary || group_q == '0)) in_grp_q <= '0;
        else if (inc)                           in_grp_q <= nxt_cnt;
    end

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (group_q == '0) || (in_grp_q < group_q));
    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_grp_q == '0));
endmodule

// File: rtl/pace_pause_timer.sv
// Pause timer: counts millisecond ticks down from TICKS after a start and
// flags expiry on the last one. Assumes start is never raised while busy.
module pace_pause_timer #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic expire
);
    localparam int LW = $clog2(TICKS + 1);
    localparam logic [LW-1:0] LOAD = LW'(TICKS);
    localparam logic [LW-1:0] ONE  = LW'(1);

    logic [LW-1:0] left_q;

    // Busy while ticks remain; expiry on the last tick.
    always_comb begin
        busy   = (left_q != '0);
        expire = busy && tick && (left_q == ONE);
    end

    // Load on start, count down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (start)        left_q <= LOAD;
        else if (busy && tick) left_q <= left_q - ONE;
    end

    // R6
    left_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LOAD);
    // R6
    expire_ends_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !busy);
    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (left_q == $past(left_q)));
endmodule

// File: rtl/tx_pace_limiter.sv
// Transmit pacing limiter: raises a transmit-ready event for each enabled
// write, except the write that completes a group, which starts a pause;
// the event is released when the pause expires.
// Assumes strobes are single-cycle and synchronous to clk.
module tx_pace_limiter
    import pace_pkg::*;
#(
    parameter int PAUSE_TICKS = MS_PER_PAUSE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_wr,
    input  logic        baud_load,
    input  logic [31:0] baud_in,
    input  logic        tx_int_en,
    input  logic        ms_tick,
    output logic        tx_ready_pulse,
    output logic        pace_busy
);
    logic commit_ok, boundary, busy, expire, start_pause, ready_now;
    cnt_t group_q, in_grp_q;

    pace_group_calc u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_load (baud_load),
        .baud_in   (baud_in),
        .commit_ok (commit_ok),
        .group_q   (group_q)
    );

    pace_byte_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (commit_ok),
        .inc      (byte_wr),
        .group_q  (group_q),
        .boundary (boundary),
        .in_grp_q (in_grp_q)
    );

    pace_pause_timer #(.TICKS(PAUSE_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_pause),
        .tick   (ms_tick),
        .busy   (busy),
        .expire (expire)
    );

    // Decide between an immediate event and a new pause for this write.
    always_comb begin
        start_pause = byte_wr && tx_int_en && boundary && !busy;
        ready_now   = (byte_wr && tx_int_en && !boundary) || expire;
    end

    // Register the one-cycle transmit-ready event.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_ready_pulse <= 1'b0;
        else        tx_ready_pulse <= ready_now;
    end

    assign pace_busy = busy;

    // R4
    pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_pulse |-> ($past(byte_wr && tx_int_en) || $past(expire)));
    // R5
    pause_from_enabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pace_busy) |-> $past(byte_wr && tx_int_en && group_q != '0));
    // R7
    disabled_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && !tx_int_en && !expire) |=> !tx_ready_pulse);
    // R3
    zero_group_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (group_q == '0 && !busy) |=> !pace_busy);
endmodule

// File: tb/tb_tx_pace_limiter.sv
`timescale 1ns/1ps
module tb_tx_pace_limiter;
    localparam int PT = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic byte_wr = 1'b0, baud_load = 1'b0, tx_int_en = 1'b0, ms_tick = 1'b0;
    logic [31:0] baud_in = '0;
    logic tx_ready_pulse, pace_busy;

    int n_chk = 0, n_fail = 0, cycles = 0;

    always #2.5 clk = ~clk;

    tx_pace_limiter #(.PAUSE_TICKS(PT)) dut (
        .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .baud_load(baud_load),
        .baud_in(baud_in), .tx_int_en(tx_int_en), .ms_tick(ms_tick),
        .tx_ready_pulse(tx_ready_pulse), .pace_busy(pace_busy)
    );

    // Table: committed baud rate and the group size it must give (R2, R3).
    typedef struct packed { logic [31:0] baud; logic [31:0] grp; } row_t;
    localparam int NROW = 7;
    localparam row_t TABLE [NROW] = '{
        '{32'd9600,   32'd10},
        '{32'd8000,   32'd10},
        '{32'd7999,   32'd0},
        '{32'd19200,  32'd20},
        '{32'd38400,  32'd40},
        '{32'd2400,   32'd0},
        '{32'd115200, 32'd140}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic wr();
        byte_wr = 1'b1; @(negedge clk); byte_wr = 1'b0;
    endtask
    task automatic tk();
        ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
    endtask
    task automatic commit(logic [31:0] b);
        baud_in = b; baud_load = 1'b1; @(negedge clk); baud_load = 1'b0;
    endtask

    // Write bytes; count writes until busy rises, and pulses before it.
    task automatic measure(string req, int exp);
        int pos = 0, pulses = 0;
        int lim = (exp == 0) ? 20 : exp + 2;
        for (int i = 1; i <= lim && pos == 0; i++) begin
            wr();
            if (pace_busy) pos = i; else if (tx_ready_pulse) pulses++;
        end
        check({req, " group position"}, pos, exp);
        check({req, " pulses before pause"}, pulses, (exp == 0) ? 20 : exp - 1);
    endtask

    // Tick out a running pause, checking the last two ticks.
    task automatic end_pause(string req);
        for (int i = 1; i < PT; i++) tk();
        check({req, " busy before last tick"}, {tx_ready_pulse, pace_busy}, 2'b01);
        tk();
        check({req, " expiry pulse"}, {tx_ready_pulse, pace_busy}, 2'b10);
        @(negedge clk);
        check({req, " pulse one cycle"}, tx_ready_pulse, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", pace_busy, 0);
        check("R1 reset pulse", tx_ready_pulse, 0);
        rst_n = 1'b1; tx_int_en = 1'b1;
        @(negedge clk);
        // R1: default group 140 without any commit
        measure("R1", 140);
        end_pause("R6");

        // R2/R3 table walk
        for (int r = 0; r < NROW; r++) begin
            commit(TABLE[r].baud);
            measure((TABLE[r].grp == 0) ? "R3" : "R2", int'(TABLE[r].grp));
            if (TABLE[r].grp != 0) end_pause("R6");
        end

        // R4: single-cycle pulse after a plain write
        commit(32'd9600);
        wr();
        check("R4 pulse", {tx_ready_pulse, pace_busy}, 2'b10);
        @(negedge clk);
        check("R4 pulse width", tx_ready_pulse, 0);

        // R6: ticks while idle do nothing
        tk(); tk();
        check("R6 idle tick", {tx_ready_pulse, pace_busy}, 2'b00);

        // R7: disabled writes counted silently (1 enabled + 4 disabled)
        tx_int_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wr();
            check("R7 disabled write", {tx_ready_pulse, pace_busy}, 2'b00);
        end
        tx_int_en = 1'b1;
        measure("R7 remaining", 5);
        // R6: expiry ignores enable
        tx_int_en = 1'b0;
        end_pause("R6 enable clear");
        tx_int_en = 1'b1;

        // R8: writes during pause counted, pause not extended
        measure("R8 setup", 10);
        for (int i = 0; i < 5; i++) tk();
        for (int i = 0; i < 3; i++) begin
            wr();
            check("R8 write in pause", {tx_ready_pulse, pace_busy}, 2'b11);
        end
        for (int i = 0; i < 4; i++) tk();
        check("R8 not extended busy", pace_busy, 1);
        tk();
        check("R8 not extended expiry", {tx_ready_pulse, pace_busy}, 2'b10);
        measure("R8 counted", 7);
        // R8: boundary inside a pause absorbed
        for (int i = 0; i < 9; i++) wr();
        check("R8 nine in pause", {tx_ready_pulse, pace_busy}, 2'b11);
        wr();
        check("R8 boundary absorbed", {tx_ready_pulse, pace_busy}, 2'b01);
        end_pause("R8 original pause");

        // R9: zero commit ignored, count kept
        for (int i = 0; i < 3; i++) wr();
        commit(32'd0);
        measure("R9 zero commit", 7);
        end_pause("R9");
        // R9: valid commit restarts count
        for (int i = 0; i < 3; i++) wr();
        commit(32'd9600);
        measure("R9 restart", 10);
        end_pause("R9");
        // R9: commit beats a same-cycle write
        for (int i = 0; i < 3; i++) wr();
        baud_in = 32'd9600; baud_load = 1'b1; byte_wr = 1'b1;
        @(negedge clk);
        baud_load = 1'b0; byte_wr = 1'b0;
        measure("R9 priority", 10);
        end_pause("R9");

        finish_run();
    end
endmodule